// File: doc/BRIEF.md
# AXI4 Burst Write Slave

This block is the write half of an AXI4 slave. It takes one write address on the AW channel, accepts that burst's data beats on the W channel until the beat marked last, stores each beat locally and then returns one response on the B channel. Only one burst is in progress at a time. A four-state controller sequences the work through reset, address wait, data wait and response wait.

The burst type selects where the data goes. A FIXED burst targets a single address, so its beats are queued in order into an internal FIFO. A peripheral drains that FIFO through a pop port. An INCR burst writes successive words of an internal RAM. Each beat's byte address advances by 2^size from the start address, and the byte strobes select which bytes of the word are written. The peripheral reads the RAM through a combinational read port. The reset input may be asserted at any moment. Its release is synchronised to the clock, and asserting it abandons any burst in progress.

Top module: `axi_burst_wr_slave`

## Requirements
- R1: While rst_n is low, aw_ready, w_ready and b_valid are 0 and fifo_empty is 1. aw_ready first reads 1 after the third rising clock edge following the release of rst_n.
- R2: w_ready stays 0 until an AW handshake has completed. W beats presented before that are not accepted and leave the FIFO empty.
- R3: After the AW handshake, beats are accepted (w_valid and w_ready high at a rising edge) until the beat with w_last = 1, which ends the data phase.
- R4: Exactly one B response is given per burst, after its last beat. b_id equals the captured aw_id, and b_valid, b_id and b_resp hold steady until b_ready is seen high. b_valid drops after the handshake.
- R5: For an INCR burst (aw_burst = 2'b01), beat n is written at byte address start + n*2^aw_size. The RAM word index is bits [7:2] of that byte address, with 32-bit words and 64 words, and it wraps modulo 64.
- R6: In an INCR beat, RAM byte lane k (bits 8k+7..8k) is written only when w_strb[k] is 1. Other lanes keep their old value.
- R7: For a FIXED burst (aw_burst = 2'b00), the beats are pushed in arrival order into an 8-entry FIFO. fifo_data shows the oldest entry and fifo_pop removes it.
- R8: If a FIXED beat arrives while the FIFO holds 8 entries, that beat is dropped and the burst's b_resp is 2'b10. Otherwise b_resp is 2'b00.
- R9: A burst of 256 beats (aw_len = 255) is accepted in full and answered with one response.
- R10: Asserting rst_n in the middle of a burst abandons it. No B response is issued, the FIFO is emptied, and after release the slave accepts a new burst normally.
- R11: While a response is pending, w_ready and aw_ready are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| aw_id | input | 4 | Write transaction ID |
| aw_addr | input | 12 | Burst start byte address |
| aw_len | input | 8 | Beats in burst minus one |
| aw_size | input | 3 | log2 of bytes per beat (0..2) |
| aw_burst | input | 2 | 00 FIXED to FIFO, 01 INCR to RAM |
| aw_valid | input | 1 | Address valid |
| aw_ready | output | 1 | Address accepted |
| w_data | input | 32 | Beat data |
| w_strb | input | 4 | Byte lane enables |
| w_last | input | 1 | Final beat of burst |
| w_valid | input | 1 | Beat valid |
| w_ready | output | 1 | Beat accepted |
| b_id | output | 4 | Response ID, echo of aw_id |
| b_resp | output | 2 | 00 OKAY, 10 SLVERR |
| b_valid | output | 1 | Response valid |
| b_ready | input | 1 | Response accepted |
| fifo_pop | input | 1 | Remove oldest FIFO entry |
| fifo_data | output | 32 | Oldest FIFO entry |
| fifo_empty | output | 1 | FIFO holds nothing |
| ram_raddr | input | 6 | RAM word read index |
| ram_rdata | output | 32 | RAM word at ram_raddr |

## Verification
The embedded properties check several rules on every clock cycle. The response holds steady under back-pressure and is released after its handshake. A last beat always leads to a response. The channels stay closed while a response is pending. An error response only comes from a FIXED burst. The INCR address advances by the beat size, and the FIFO is never pushed while full. The bench scenarios cover what the properties cannot see. These are the actual RAM contents under sub-word sizes, partial strobes and index wrap, the order and content of the FIFO, the exact timing of reset release, and recovery after a burst is abandoned.

// File: rtl/axw_pkg.sv
package axw_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_ADDR  = 2'd1,
    ST_DATA  = 2'd2,
    ST_RESP  = 2'd3
  } wr_state_e;

  localparam logic [1:0] BURST_FIXED = 2'b00;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/axw_rst_sync.sv
module axw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/axw_fifo.sv
module axw_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic              do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      if (do_push != do_pop) count <= do_push ? count + 1'b1 : count - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R8
endmodule

// File: rtl/axw_ram.sv
module axw_ram #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W/8-1:0]      wstrb,
  input  logic [$clog2(WORDS)-1:0] raddr,
  output logic [DATA_W-1:0]        rdata
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (we && wstrb[k]) mem[waddr][8*k +: 8] <= wdata[8*k +: 8];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/axi_burst_wr_slave.sv
module axi_burst_wr_slave
  import axw_pkg::*;
#(
  parameter int ID_W       = 4,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int RAM_WORDS  = 64,
  parameter int FIFO_DEPTH = 8,
  localparam int STRB_W    = DATA_W / 8,
  localparam int LANE_W    = $clog2(STRB_W),
  localparam int RAM_AW    = $clog2(RAM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [7:0]        aw_len,
  input  logic [2:0]        aw_size,
  input  logic [1:0]        aw_burst,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [DATA_W-1:0] w_data,
  input  logic [STRB_W-1:0] w_strb,
  input  logic              w_last,
  input  logic              w_valid,
  output logic              w_ready,
  output logic [ID_W-1:0]   b_id,
  output logic [1:0]        b_resp,
  output logic              b_valid,
  input  logic              b_ready,
  input  logic              fifo_pop,
  output logic [DATA_W-1:0] fifo_data,
  output logic              fifo_empty,
  input  logic [RAM_AW-1:0] ram_raddr,
  output logic [DATA_W-1:0] ram_rdata
);
  logic              rst_sync_n;
  wr_state_e         state_q, state_d;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q, step;
  logic [2:0]        size_q, eff_size;
  logic [7:0]        len_q, beats_q;
  logic              fixed_q, err_q;
  logic              aw_hs, w_hs, fifo_full, fifo_push, ram_we;

  axw_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign aw_ready = (state_q == ST_ADDR);
  assign w_ready  = (state_q == ST_DATA);
  assign b_valid  = (state_q == ST_RESP);
  assign b_id     = id_q;
  assign b_resp   = err_q ? RESP_SLVERR : RESP_OKAY;
  assign aw_hs    = aw_valid && aw_ready;
  assign w_hs     = w_valid && w_ready;

  assign eff_size = (size_q > 3'(LANE_W)) ? 3'(LANE_W) : size_q;
  assign step     = ADDR_W'(1) << eff_size;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RESET: state_d = ST_ADDR;
      ST_ADDR:  if (aw_hs) state_d = ST_DATA;
      ST_DATA:  if (w_hs && w_last) state_d = ST_RESP;
      ST_RESP:  if (b_ready) state_d = ST_ADDR;
      default:  state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_RESET;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      id_q    <= '0;
      addr_q  <= '0;
      size_q  <= '0;
      len_q   <= '0;
      beats_q <= '0;
      fixed_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (aw_hs) begin
      id_q    <= aw_id;
      addr_q  <= aw_addr;
      size_q  <= aw_size;
      len_q   <= aw_len;
      beats_q <= '0;
      fixed_q <= (aw_burst == BURST_FIXED);
      err_q   <= 1'b0;
    end else if (w_hs) begin
      beats_q <= beats_q + 1'b1;
      if (!fixed_q)             addr_q <= addr_q + step;
      if (fixed_q && fifo_full) err_q  <= 1'b1;
    end
  end

  assign fifo_push = w_hs && fixed_q && !fifo_full;
  assign ram_we    = w_hs && !fixed_q;

  axw_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_sync_n), .push(fifo_push), .wdata(w_data),
    .pop(fifo_pop), .rdata(fifo_data), .full(fifo_full), .empty(fifo_empty)
  );

  axw_ram #(.DATA_W(DATA_W), .WORDS(RAM_WORDS)) u_ram (
    .clk(clk), .we(ram_we), .waddr(addr_q[LANE_W +: RAM_AW]), .wdata(w_data),
    .wstrb(w_strb), .raddr(ram_raddr), .rdata(ram_rdata)
  );

  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    b_valid && !b_ready |=> b_valid && $stable(b_id) && $stable(b_resp)); // R4
  AST_B_RELEASE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    b_valid && b_ready |=> !b_valid); // R4
  AST_LAST_TO_B: assert property (@(posedge clk) disable iff (!rst_sync_n)
    w_hs && w_last |=> b_valid); // R3
  AST_LEN_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    w_hs && w_last |-> beats_q == len_q); // R9
  AST_QUIET_IN_RESP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    b_valid |-> !w_ready && !aw_ready); // R11
  AST_SLVERR_FIXED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    b_valid && b_resp == RESP_SLVERR |-> fixed_q); // R8
  AST_INCR_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ram_we && !w_last |=> addr_q == $past(addr_q) + $past(step)); // R5
endmodule

// File: tb/tb_axi_burst_wr_slave.sv
module tb_axi_burst_wr_slave;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic [3:0]  aw_id;
  logic [11:0] aw_addr;
  logic [7:0]  aw_len;
  logic [2:0]  aw_size;
  logic [1:0]  aw_burst;
  logic        aw_valid, aw_ready;
  logic [31:0] w_data;
  logic [3:0]  w_strb;
  logic        w_last, w_valid, w_ready;
  logic [3:0]  b_id;
  logic [1:0]  b_resp;
  logic        b_valid, b_ready;
  logic        fifo_pop, fifo_empty;
  logic [31:0] fifo_data;
  logic [5:0]  ram_raddr;
  logic [31:0] ram_rdata;

  int checks = 0;
  int failures = 0;
  logic [5:0] exp_b [$];

  axi_burst_wr_slave dut (
    .clk(clk), .rst_n(rst_n), .aw_id(aw_id), .aw_addr(aw_addr), .aw_len(aw_len),
    .aw_size(aw_size), .aw_burst(aw_burst), .aw_valid(aw_valid), .aw_ready(aw_ready),
    .w_data(w_data), .w_strb(w_strb), .w_last(w_last), .w_valid(w_valid),
    .w_ready(w_ready), .b_id(b_id), .b_resp(b_resp), .b_valid(b_valid),
    .b_ready(b_ready), .fifo_pop(fifo_pop), .fifo_data(fifo_data),
    .fifo_empty(fifo_empty), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  // Scoreboard monitor: one expected response per accepted B handshake
  always @(negedge clk) begin
    #1;
    if (rst_n && b_valid && b_ready) begin
      if (exp_b.size() == 0) begin
        check(1'b0, "R4 unexpected response", {26'd0, b_id, b_resp}, 32'd0);
      end else begin
        logic [5:0] e;
        e = exp_b.pop_front();
        check({b_id, b_resp} == e, "R4/R8 response id/resp",
              {26'd0, b_id, b_resp}, {26'd0, e});
      end
    end
  end

  task automatic send_aw(input logic [3:0] id, input logic [11:0] addr,
                         input logic [7:0] len, input logic [2:0] size,
                         input logic [1:0] burst);
    aw_id = id; aw_addr = addr; aw_len = len; aw_size = size; aw_burst = burst;
    aw_valid = 1'b1;
    while (!aw_ready) @(negedge clk);
    @(negedge clk);
    aw_valid = 1'b0;
  endtask

  task automatic send_w(input logic [31:0] d, input logic [3:0] s, input logic l);
    w_data = d; w_strb = s; w_last = l; w_valid = 1'b1;
    while (!w_ready) @(negedge clk);
    @(negedge clk);
    w_valid = 1'b0;
    w_last  = 1'b0;
  endtask

  task automatic wait_b();
    while (exp_b.size() != 0) @(negedge clk);
  endtask

  task automatic ram_check(input logic [5:0] idx, input logic [31:0] exp, input string req);
    ram_raddr = idx;
    #1;
    check(ram_rdata === exp, req, ram_rdata, exp);
  endtask

  task automatic pop_check(input logic [31:0] exp, input string req);
    check(!fifo_empty && fifo_data === exp, req, fifo_data, exp);
    fifo_pop = 1'b1;
    @(negedge clk);
    fifo_pop = 1'b0;
  endtask

  initial begin
    int n;
    rst_n = 1'b0; aw_valid = 0; w_valid = 0; w_last = 0; b_ready = 1'b1;
    aw_id = 0; aw_addr = 0; aw_len = 0; aw_size = 0; aw_burst = 0;
    w_data = 0; w_strb = 0; fifo_pop = 0; ram_raddr = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!aw_ready && !w_ready && !b_valid && fifo_empty, "R1 reset outputs",
          {28'd0, aw_ready, w_ready, b_valid, fifo_empty}, 32'd1);
    rst_n = 1'b1;
    n = 0;
    while (!aw_ready && n < 10) begin @(negedge clk); n++; end
    check(n == 3, "R1 release latency", n, 3);

    // R2: beats before the address are refused
    w_valid = 1'b1; w_last = 1'b1; w_data = 32'hDEAD0000;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!w_ready, "R2 w_ready before AW", {31'd0, w_ready}, 0);
    end
    w_valid = 1'b0; w_last = 1'b0;
    check(fifo_empty && !b_valid, "R2 nothing stored", {30'd0, fifo_empty, b_valid}, 2);

    // R3/R5: INCR size 2, start word 4
    exp_b.push_back({4'd3, 2'b00});
    send_aw(4'd3, 12'h010, 8'd3, 3'd2, 2'b01);
    for (int i = 0; i < 4; i++) send_w(32'hC0DE0000 + i, 4'hF, i == 3);
    wait_b();
    for (int i = 0; i < 4; i++) ram_check(6'(4 + i), 32'hC0DE0000 + i, "R5 incr word");

    // R5/R6: INCR size 1 steps two bytes
    exp_b.push_back({4'd4, 2'b00});
    send_aw(4'd4, 12'h040, 8'd3, 3'd1, 2'b01);
    send_w(32'h1111AAAA, 4'b0011, 1'b0);
    send_w(32'hBBBB2222, 4'b1100, 1'b0);
    send_w(32'h3333CCCC, 4'b0011, 1'b0);
    send_w(32'hDDDD4444, 4'b1100, 1'b1);
    wait_b();
    ram_check(6'd16, 32'hBBBBAAAA, "R5 halfword step word16");
    ram_check(6'd17, 32'hDDDDCCCC, "R5 halfword step word17");

    // R6: partial strobe keeps other lanes
    exp_b.push_back({4'd1, 2'b00});
    send_aw(4'd1, 12'h050, 8'd0, 3'd2, 2'b01);
    send_w(32'h11223344, 4'hF, 1'b1);
    wait_b();
    exp_b.push_back({4'd1, 2'b00});
    send_aw(4'd1, 12'h050, 8'd0, 3'd2, 2'b01);
    send_w(32'hAABBCCDD, 4'b0101, 1'b1);
    wait_b();
    ram_check(6'd20, 32'h11BB33DD, "R6 strobe gating");

    // R7/R11/R4: FIXED into FIFO with stalled response
    b_ready = 1'b0;
    exp_b.push_back({4'd5, 2'b00});
    send_aw(4'd5, 12'h300, 8'd1, 3'd2, 2'b00);
    send_w(32'hE0E0E0E0, 4'hF, 1'b0);
    send_w(32'hE1E1E1E1, 4'hF, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(b_valid && !w_ready && !aw_ready && b_id == 4'd5, "R11 stalled response",
            {28'd0, b_valid, w_ready, aw_ready, 1'b0}, 32'h8);
    end
    b_ready = 1'b1;
    wait_b();
    @(negedge clk);
    check(!b_valid, "R4 b_valid drops", {31'd0, b_valid}, 0);
    pop_check(32'hE0E0E0E0, "R7 fifo first");
    pop_check(32'hE1E1E1E1, "R7 fifo second");
    check(fifo_empty, "R7 fifo drained", {31'd0, fifo_empty}, 1);

    // R8: overflow of FIFO gives error
    exp_b.push_back({4'd6, 2'b10});
    send_aw(4'd6, 12'h300, 8'd9, 3'd2, 2'b00);
    for (int i = 0; i < 10; i++) send_w(32'hF0000000 + i, 4'hF, i == 9);
    wait_b();
    for (int i = 0; i < 8; i++) pop_check(32'hF0000000 + i, "R8 kept beats");
    check(fifo_empty, "R8 dropped beats absent", {31'd0, fifo_empty}, 1);

    // R9: 256-beat INCR burst wraps the RAM index
    exp_b.push_back({4'd7, 2'b00});
    send_aw(4'd7, 12'h000, 8'd255, 3'd2, 2'b01);
    for (int i = 0; i < 256; i++) send_w(32'hA0000000 + i, 4'hF, i == 255);
    wait_b();
    ram_check(6'd0, 32'hA0000000 + 192, "R9 long burst word0");
    ram_check(6'd5, 32'hA0000000 + 197, "R9 long burst word5");
    ram_check(6'd63, 32'hA0000000 + 255, "R9 long burst word63");

    // R10: reset in mid burst
    exp_b.push_back({4'd8, 2'b00});
    send_aw(4'd8, 12'h300, 8'd3, 3'd2, 2'b00);
    send_w(32'h55550000, 4'hF, 1'b0);
    void'(exp_b.pop_back());
    rst_n = 1'b0;
    #1;
    check(!aw_ready && !w_ready && !b_valid && fifo_empty, "R10 abandon on reset",
          {28'd0, aw_ready, w_ready, b_valid, fifo_empty}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!aw_ready && n < 10) begin @(negedge clk); n++; end
    check(aw_ready && !b_valid, "R10 ready after reset", {30'd0, aw_ready, b_valid}, 2);
    exp_b.push_back({4'd9, 2'b00});
    send_aw(4'd9, 12'h300, 8'd0, 3'd2, 2'b00);
    send_w(32'h99999999, 4'hF, 1'b1);
    wait_b();
    pop_check(32'h99999999, "R10 recovery burst");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule